// File: doc/BRIEF.md
# Pulse-Swallow Divide Controller

This block is the digital back end of a pulse-swallow frequency divider. It runs on the output clock of a fixed 64/65 dual-modulus prescaler and drives the prescaler's modulus-select line. Each divide cycle lasts N prescaler periods. During the first A of those periods it asks for divide-by-65, and for the rest it asks for divide-by-64. The input frequency is therefore divided by 64·N + A overall. Once per cycle it raises a single-period pulse on the last prescaler period, and that pulse feeds a phase comparator.

New settings come in on a write strobe and are held in a staging register. The counters take the staged values only at the edge that ends a cycle. A cycle is never cut short or stretched by a write, and the counters never load half-updated values. A write that asks for an unusable setting (N below 5, or A not smaller than N) is refused, and the staged setting stays as it was. The bench keeps A below N for every setting it expects to be accepted.

Top module: `swallow_div_ctrl`

## Requirements
- R1: A synchronous active-high reset starts a cycle with the reset defaults N=20, A=3. The reset edge stages these same values, drives div_pulse low and drives mod_hi high, because A is nonzero.
- R2: div_pulse is high for exactly one clock, on the last of the N clocks of each cycle, and is low on every other clock.
- R3: mod_hi is 1 (requesting divide-by-65) on the first A clocks of each cycle and 0 (divide-by-64) on the remaining N−A clocks.
- R4: In each cycle, the prescaler input periods sum to 64·N + A, counting 65 for each clock with mod_hi=1 and 64 for each clock with mod_hi=0.
- R5: An accepted write is applied only at the next cycle boundary. A write sampled on the same edge that ends a cycle is applied at the boundary after that one.
- R6: A write with cfg_n < 5 or cfg_a ≥ cfg_n is ignored. The following cycles keep the previously staged N and A.
- R7: With A = 0, mod_hi stays 0 for the whole cycle.
- R8: The largest setting, N=4095 with A=63, gives a total division of 262,143.
- R9: When several accepted writes land within one cycle, the last of them sets the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for a new setting |
| cfg_a | input | 6 | Swallow count A to stage |
| cfg_n | input | 12 | Main count N to stage |
| mod_hi | output | 1 | Modulus select: 1 = divide-by-65, 0 = divide-by-64 |
| div_pulse | output | 1 | One-clock pulse on the last clock of each cycle |

## Verification
The bench aims at the cycle boundary. It writes on the terminal clock itself, mid-cycle, and more than once per cycle. A design that reloaded from the new value too early would produce a cycle of mixed length. Refused settings and A=0 are also applied. A design without the filter would stage a value with A≥N and hold mod_hi high through the pulse. A design that mishandled A=0 would wrap the swallow counter and request divide-by-65 for 63 periods. The largest setting exercises the full counter widths, so a truncated counter would show up as a short period.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int SWC_A_W   = 6;
  localparam int SWC_N_W   = 12;
  localparam int SWC_N_MIN = 5;
  localparam int SWC_RST_A = 3;
  localparam int SWC_RST_N = 20;
endpackage

// File: rtl/swc_cfg_hold.sv
module swc_cfg_hold #(
  parameter int A_W   = swc_pkg::SWC_A_W,
  parameter int N_W   = swc_pkg::SWC_N_W,
  parameter int N_MIN = swc_pkg::SWC_N_MIN,
  parameter int RST_A = swc_pkg::SWC_RST_A,
  parameter int RST_N = swc_pkg::SWC_RST_N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [A_W-1:0] wr_a,
  input  logic [N_W-1:0] wr_n,
  output logic [A_W-1:0] pend_a,
  output logic [N_W-1:0] pend_n
);
  logic n_ok, a_ok, wr_ok;

  assign n_ok  = (wr_n >= N_W'(N_MIN));
  assign a_ok  = (N_W'(wr_a) < wr_n);
  assign wr_ok = wr && n_ok && a_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a <= A_W'(RST_A);
      pend_n <= N_W'(RST_N);
    end else if (wr_ok) begin
      pend_a <= wr_a;
      pend_n <= wr_n;
    end
  end

  assert_refused_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> ($stable(pend_a) && $stable(pend_n)));
  assert_staged_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_n >= N_W'(N_MIN)) && (N_W'(pend_a) < pend_n));
endmodule

// File: rtl/swc_main_cnt.sv
module swc_main_cnt #(
  parameter int N_W   = swc_pkg::SWC_N_W,
  parameter int RST_N = swc_pkg::SWC_RST_N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] load_n,
  output logic           term
);
  logic [N_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= N_W'(RST_N - 1);
      term   <= 1'b0;
    end else if (term) begin
      left_q <= load_n - N_W'(1);
      term   <= 1'b0;
    end else begin
      left_q <= left_q - N_W'(1);
      term   <= (left_q == N_W'(1));
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    term |=> !term);
  assert_term_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
    term |-> (left_q == '0));
endmodule

// File: rtl/swc_swallow_cnt.sv
module swc_swallow_cnt #(
  parameter int A_W   = swc_pkg::SWC_A_W,
  parameter int RST_A = swc_pkg::SWC_RST_A
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reload,
  input  logic [A_W-1:0] load_a,
  output logic           mod_hi
);
  logic [A_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= A_W'(RST_A);
      mod_hi <= (RST_A != 0);
    end else if (reload) begin
      left_q <= load_a;
      mod_hi <= (load_a != '0);
    end else if (left_q != '0) begin
      left_q <= left_q - A_W'(1);
      mod_hi <= (left_q > A_W'(1));
    end
  end

  assert_rise_on_reload_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_hi) |-> $past(reload));
  assert_zero_swallow_low_R7: assert property (@(posedge clk) disable iff (rst)
    (reload && load_a == '0) |=> !mod_hi);
endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl #(
  parameter int A_W   = swc_pkg::SWC_A_W,
  parameter int N_W   = swc_pkg::SWC_N_W,
  parameter int N_MIN = swc_pkg::SWC_N_MIN,
  parameter int RST_A = swc_pkg::SWC_RST_A,
  parameter int RST_N = swc_pkg::SWC_RST_N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [A_W-1:0] cfg_a,
  input  logic [N_W-1:0] cfg_n,
  output logic           mod_hi,
  output logic           div_pulse
);
  logic [A_W-1:0] pend_a;
  logic [N_W-1:0] pend_n;

  swc_cfg_hold #(.A_W(A_W), .N_W(N_W), .N_MIN(N_MIN), .RST_A(RST_A), .RST_N(RST_N)) u_hold (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_a(cfg_a), .wr_n(cfg_n),
    .pend_a(pend_a), .pend_n(pend_n));

  swc_main_cnt #(.N_W(N_W), .RST_N(RST_N)) u_main (
    .clk(clk), .rst(rst), .load_n(pend_n), .term(div_pulse));

  swc_swallow_cnt #(.A_W(A_W), .RST_A(RST_A)) u_swallow (
    .clk(clk), .rst(rst), .reload(div_pulse), .load_a(pend_a), .mod_hi(mod_hi));

  assert_low_modulus_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> !mod_hi);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!div_pulse && (mod_hi == (RST_A != 0))));
endmodule

// File: tb/swallow_div_ctrl_tb.sv
module swallow_div_ctrl_tb;
  localparam int RN = 20;
  localparam int RA = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [5:0] cfg_a = '0;
  logic [11:0] cfg_n = '0;
  logic mod_hi, div_pulse;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string focus = "R1";

  int p, cur_n, cur_a, pend_n, pend_a, acc;
  bit live = 1'b0;

  always #2 clk = ~clk;

  swallow_div_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_a(cfg_a), .cfg_n(cfg_n),
    .mod_hi(mod_hi), .div_pulse(div_pulse));

  // behavioural reference: position within cycle plus staged settings
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      p = 0; cur_n = RN; cur_a = RA; pend_n = RN; pend_a = RA; acc = 0;
      live = 1'b1;
    end else begin
      if (p == cur_n - 1) begin
        p = 0; cur_n = pend_n; cur_a = pend_a;
      end else begin
        p++;
      end
      if (cfg_wr && int'(cfg_n) >= 5 && int'(cfg_a) < int'(cfg_n)) begin
        pend_n = int'(cfg_n); pend_a = int'(cfg_a);
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      bit exp_mod, exp_pulse;
      exp_mod   = (p < cur_a);
      exp_pulse = (p == cur_n - 1);
      vectors++;
      if (mod_hi !== exp_mod) begin
        fails++;
        $display("FAIL %s/R3 mod_hi got %0b expected %0b (pos %0d, N %0d, A %0d)",
                 focus, mod_hi, exp_mod, p, cur_n, cur_a);
      end
      if (div_pulse !== exp_pulse) begin
        fails++;
        $display("FAIL %s/R2 div_pulse got %0b expected %0b (pos %0d, N %0d)",
                 focus, div_pulse, exp_pulse, p, cur_n);
      end
      if (!rst) begin
        acc += (mod_hi === 1'b1) ? 65 : 64;
        if (div_pulse === 1'b1) begin
          vectors++;
          if (acc != 64 * cur_n + cur_a) begin
            fails++;
            $display("FAIL %s/R4 division got %0d expected %0d", focus, acc, 64 * cur_n + cur_a);
          end
          acc = 0;
        end
      end
    end
  end

  task automatic put(input int n, input int a);
    cfg_n = 12'(n); cfg_a = 6'(a); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic wait_term();
    while (div_pulse !== 1'b1) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    focus = "R1"; idle(2);
    focus = "R2"; idle(50);
    focus = "R5"; idle(5); put(10, 7); idle(45);
    focus = "R5"; wait_term(); put(12, 5); idle(40);
    focus = "R6"; put(4, 0); idle(5); put(8, 8); idle(5); put(9, 20); idle(40);
    focus = "R7"; put(6, 0); idle(30);
    focus = "R9"; wait_term(); idle(1); put(15, 2); put(7, 6); idle(40);
    focus = "R3"; put(33, 32); idle(80);
    focus = "R8"; put(4095, 63); idle(8400);
    focus = "R1"; rst = 1'b1; idle(2); rst = 1'b0; idle(60);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog expired in %s", focus);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule